// File: doc/BRIEF.md
# Trace Word Nibble Serializer with Two-Entry Buffer

This block sits between a processor pipeline and a narrow debug data port. The pipeline hands it 32-bit trace words, such as computed branch targets or operand values, together with a size tag. The block queues them in a two-entry first-in first-out buffer and sends each one out on a 4-bit port, one nibble per trace clock, lowest nibble first. An external development system reads the stream and rebuilds indirect change-of-flow targets from it.

The core is held back only when both entries contain words that are still being sent. A capture that arrives in the cycle in which the head word sends its last nibble is taken at once, so the stall never lasts longer than the drain of one word. All outputs change on the trace clock, and a synchronous active-high reset empties the buffer.

Top module: `trace_nibble_fifo`

## Requirements
- R1: Captured words leave the data port in the order in which they were accepted, and no word is lost or repeated.
- R2: Within a word the nibbles go out in ascending significance: bits 3:0 first, then 7:4, and so on, one nibble per clock.
- R3: The size tag sets how many nibbles a word sends: 2'b00 (byte) sends 2, 2'b01 (16-bit) sends 4, and 2'b10 or 2'b11 (32-bit) send 8. The marker stays high for exactly that many consecutive cycles per word.
- R4: The stall output is high exactly when both entries are occupied and the head word is not showing its final nibble in the current cycle.
- R5: A capture is accepted on any clock edge on which the stall is low, including the edge on which the head entry frees. A capture presented while the stall is high has no effect.
- R6: With the buffer empty the data port is 4'h0 and the marker is low.
- R7: A synchronous active-high reset empties both entries. In the cycle after a reset edge the marker and stall are low and the data port is 4'h0.
- R8: A word accepted into an empty buffer shows its first nibble in the cycle right after the accepting edge, and a queued word follows the previous word's final nibble without a gap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Trace clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | A trace word is presented this cycle |
| cap_word | input | 32 | Trace word to capture |
| cap_size | input | 2 | Size tag: 00 byte, 01 16-bit, 10 or 11 32-bit |
| ddata | output | 4 | Current nibble of the head word, 0 when idle |
| ddata_vld | output | 1 | High when ddata carries a trace nibble |
| stall | output | 1 | Request to hold the core; the capture is not taken |

## Verification
The bench builds the block with its default values: a 32-bit word, 4-bit nibbles and two entries. With so few entries, a sweep over every size tag plus a mixed pattern, and over idle gaps of zero to five cycles between captures, reaches every occupancy state. It also reaches the full-buffer case in which the head sends its last nibble while a new capture is waiting. Each pattern runs once with the core holding a stalled word and once with the core dropping it, which separates R5's "accepted on free" edge from its "ignored while stalled" edge. A reset with both entries full closes the run.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LNG2 = 2'b11
  } trc_size_e;

  // Number of payload bits carried by a word of the given size tag.
  function automatic int unsigned size_bits(input logic [1:0] tag);
    case (tag)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 32;
    endcase
  endfunction

  // Index of the final nibble for a tag, given the nibble width.
  function automatic int unsigned last_nibble(input logic [1:0] tag,
                                              input int unsigned nib_w);
    return (size_bits(tag) / nib_w) - 1;
  endfunction

  // Next value of a wrapping pointer over a ring of the given depth.
  function automatic int unsigned ring_next(input int unsigned ptr,
                                            input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/trc_buffer.sv
module trc_buffer #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [1:0]        wr_size,
  output logic [WORD_W-1:0] head_word,
  output logic [1:0]        head_size,
  output logic              head_valid,
  output logic              full,
  output logic [CNT_W-1:0]  occ
);
  import trc_pkg::*;

  localparam logic [CNT_W-1:0] OCC_FULL = CNT_W'(DEPTH);

  logic [WORD_W-1:0] word_q [DEPTH];
  logic [1:0]        size_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (push && (wr_ptr == PTR_W'(g))) begin
          word_q[g] <= wr_word;
          size_q[g] <= wr_size;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ring_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ring_next(32'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   occ <= occ + CNT_W'(1);
        2'b01:   occ <= occ - CNT_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign head_word  = word_q[rd_ptr];
  assign head_size  = size_q[rd_ptr];
  assign head_valid = (occ != '0);
  assign full       = (occ == OCC_FULL);

endmodule

// File: rtl/trc_serializer.sv
module trc_serializer #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned NIBS  = WORD_W / NIB_W,
  localparam int unsigned IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic [WORD_W-1:0] head_word,
  input  logic [1:0]        head_size,
  output logic              last_nib,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_vld
);
  import trc_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_last;
  logic [NIB_W-1:0] nib_arr [NIBS];

  genvar g;
  generate
    for (g = 0; g < NIBS; g++) begin : g_slice
      assign nib_arr[g] = head_word[g*NIB_W +: NIB_W];
    end
  endgenerate

  assign idx_last = IDX_W'(last_nibble(head_size, NIB_W));
  assign last_nib = head_valid && (idx_q == idx_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (head_valid) begin
      idx_q <= last_nib ? '0 : idx_q + IDX_W'(1);
    end
  end

  assign nib_vld = head_valid;
  assign nib_out = head_valid ? nib_arr[idx_q] : '0;

endmodule

// File: rtl/trace_nibble_fifo.sv
module trace_nibble_fifo #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_word,
  input  logic [1:0]        cap_size,
  output logic [NIB_W-1:0]  ddata,
  output logic              ddata_vld,
  output logic              stall
);

  logic [WORD_W-1:0] head_word;
  logic [1:0]        head_size;
  logic              head_valid;
  logic              buf_full;
  logic [CNT_W-1:0]  occ;
  logic              last_nib;

  // Named events for the checker.
  logic push_evt;
  logic pop_evt;

  assign pop_evt  = last_nib;
  assign stall    = buf_full && !pop_evt;
  assign push_evt = cap_valid && !stall;

  trc_buffer #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_buf (
    .clk        (clk),
    .rst        (rst),
    .push       (push_evt),
    .pop        (pop_evt),
    .wr_word    (cap_word),
    .wr_size    (cap_size),
    .head_word  (head_word),
    .head_size  (head_size),
    .head_valid (head_valid),
    .full       (buf_full),
    .occ        (occ)
  );

  trc_serializer #(
    .WORD_W (WORD_W),
    .NIB_W  (NIB_W)
  ) u_ser (
    .clk        (clk),
    .rst        (rst),
    .head_valid (head_valid),
    .head_word  (head_word),
    .head_size  (head_size),
    .last_nib   (last_nib),
    .nib_out    (ddata),
    .nib_vld    (ddata_vld)
  );

endmodule

// File: rtl/trc_fifo_checker.sv
module trc_fifo_checker #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_valid,
  input logic [WORD_W-1:0] cap_word,
  input logic [NIB_W-1:0]  ddata,
  input logic              ddata_vld,
  input logic              stall,
  input logic              push_evt,
  input logic              pop_evt,
  input logic [CNT_W-1:0]  occ
);

  localparam logic [CNT_W-1:0] OCC_FULL = CNT_W'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_FULL); // R1

  AST_FIRST_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (push_evt && occ == '0) |=> (ddata_vld && ddata == $past(cap_word[NIB_W-1:0]))); // R8

  AST_MARKER_RUN: assert property (@(posedge clk) disable iff (rst)
    (ddata_vld && !pop_evt) |=> ddata_vld); // R3

  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    stall |-> (occ == OCC_FULL && !pop_evt)); // R4

  AST_STALL_FREEZES_OCC: assert property (@(posedge clk) disable iff (rst)
    stall |=> (occ == $past(occ))); // R4

  AST_NO_STALL_WITH_ROOM: assert property (@(posedge clk) disable iff (rst)
    (occ != OCC_FULL) |-> !stall); // R5

  AST_STALLED_CAPTURE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && stall) |-> !push_evt); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ddata_vld |-> (ddata == '0)); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (occ == '0 && !stall && !ddata_vld)); // R7

endmodule

bind trace_nibble_fifo trc_fifo_checker #(
  .WORD_W (WORD_W),
  .NIB_W  (NIB_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cap_valid (cap_valid),
  .cap_word  (cap_word),
  .ddata     (ddata),
  .ddata_vld (ddata_vld),
  .stall     (stall),
  .push_evt  (push_evt),
  .pop_evt   (pop_evt),
  .occ       (occ)
);

// File: tb/trace_nibble_fifo_test.sv
module trace_nibble_fifo_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_valid = 1'b0;
  logic [31:0] cap_word = '0;
  logic [1:0]  cap_size = '0;
  logic [3:0]  ddata;
  logic        ddata_vld;
  logic        stall;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit blind_mode = 1'b0;
  bit reset_phase = 1'b0;
  bit exp_stall_now = 1'b0;

  logic [3:0] nq[$];   // expected nibbles, in send order
  int         rem[$];  // remaining nibbles per queued word
  int         hidx = 0;

  trace_nibble_fifo uut (
    .clk       (clk),
    .rst       (rst),
    .cap_valid (cap_valid),
    .cap_word  (cap_word),
    .cap_size  (cap_size),
    .ddata     (ddata),
    .ddata_vld (ddata_vld),
    .stall     (stall)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 act=%0d cycles exp=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int nibs_for(input logic [1:0] s);
    if (s == 2'b00) return 2;
    if (s == 2'b01) return 4;
    return 8;
  endfunction

  function automatic logic [31:0] gen_word(input int k, input int seed);
    return 32'hA5C3_0F96 ^ (32'(k) * 32'h0102_0408) ^ (32'(seed) * 32'h1357_9BDF);
  endfunction

  task automatic model_push(input logic [31:0] w, input logic [1:0] s);
    int n = nibs_for(s);
    for (int i = 0; i < n; i++) nq.push_back(4'((w >> (4 * i)) & 32'hF));
    rem.push_back(n);
  endtask

  // Advance one cycle, compare outputs, then consume the shown nibble.
  task automatic step();
    bit exp_vld;
    @(negedge clk);
    exp_vld = (rem.size() > 0);
    exp_stall_now = (rem.size() == 2) && (rem[0] > 1);
    if (reset_phase) begin
      chk(stall === 1'b0, "R7 stall", 32'(stall), 0);
      chk(ddata_vld === 1'b0, "R7 vld", 32'(ddata_vld), 0);
      chk(ddata === 4'h0, "R7 ddata", 32'(ddata), 0);
      return;
    end
    chk(stall === exp_stall_now, "R4 stall", 32'(stall), 32'(exp_stall_now));
    if (exp_vld) begin
      chk(ddata_vld === 1'b1, (hidx == 0) ? "R8 vld" : "R3 vld", 32'(ddata_vld), 1);
      chk(ddata === nq[0],
          blind_mode ? "R5 ddata" : ((hidx == 0) ? "R1 ddata" : "R2 ddata"),
          32'(ddata), 32'(nq[0]));
      void'(nq.pop_front());
      rem[0] = rem[0] - 1;
      hidx++;
      if (rem[0] == 0) begin
        void'(rem.pop_front());
        hidx = 0;
      end
    end else begin
      chk(ddata_vld === 1'b0, "R6 vld", 32'(ddata_vld), 0);
      chk(ddata === 4'h0, "R6 ddata", 32'(ddata), 0);
    end
  endtask

  task automatic run_seq(input int sz, input int gap, input int seed);
    int k = 0;
    int idle = 0;
    bit holding = 1'b0;
    while (k < 6) begin
      step();
      if (!holding) begin
        if (idle > 0) begin
          cap_valid = 1'b0;
          idle--;
          continue;
        end
        cap_word  = gen_word(k, seed);
        cap_size  = (sz == 4) ? 2'((k + gap) % 4) : 2'(sz);
        cap_valid = 1'b1;
      end
      if (!exp_stall_now) begin
        model_push(cap_word, cap_size);
        holding = 1'b0;
        k++;
        idle = gap;
      end else if (blind_mode) begin
        holding = 1'b0;   // dropped word: core moves on
        k++;
        idle = gap;
      end else begin
        holding = 1'b1;
      end
      if (idle > 0 || k == 6) begin
        // next cycle may be idle; inputs for this edge stay as set
      end
      if (idle == 0 && !holding && k < 6) begin
        // new word next cycle, presented after next step
      end
      if (!holding && idle > 0) begin
        // capture for this edge already set; deassert after edge
      end
    end
    step();
    cap_valid = 1'b0;
    repeat (14) step();
  endtask

  initial begin
    rst = 1'b1;
    reset_phase = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    reset_phase = 1'b0;
    repeat (2) step();

    for (int m = 0; m < 2; m++) begin
      blind_mode = (m == 1);
      for (int sz = 0; sz < 5; sz++) begin
        for (int gap = 0; gap < 6; gap++) begin
          run_seq(sz, gap, m * 100 + sz * 10 + gap);
        end
      end
    end
    blind_mode = 1'b0;

    // Reset with both entries full.
    cap_word = 32'h1357_2468; cap_size = 2'b10; cap_valid = 1'b1;
    model_push(cap_word, cap_size);
    step();
    cap_word = 32'hFEDC_BA98;
    model_push(cap_word, cap_size);
    step();
    cap_valid = 1'b0;
    step();
    rst = 1'b1;
    nq.delete();
    rem.delete();
    hidx = 0;
    reset_phase = 1'b1;
    step();
    rst = 1'b0;
    reset_phase = 1'b0;
    // Capture after reset must work from an empty state.
    cap_word = 32'h0000_C0DE; cap_size = 2'b01; cap_valid = 1'b1;
    model_push(cap_word, cap_size);
    step();
    cap_valid = 1'b0;
    repeat (8) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule